// File: doc/BRIEF.md
# Overflow-Word Arithmetic Unit

This block is the execute stage for 16-bit two-operand instructions. It takes a 4-bit opcode and two already decoded operand words, `a` and `b`, and returns the word to be written back to `a`. Arithmetic and shift operations also return a full overflow word for a dedicated overflow register, together with a write-enable for that register. The overflow word is not a single carry bit. Its meaning depends on the opcode: a carry, a borrow mask, the high half of a product, a fractional quotient, or the bits shifted out.

The datapath is combinational. A parameter `REG_OUT` places one output register after it. With the default `REG_OUT = 1`, results appear one clock after the inputs and the register clears to zero on reset. Operand decoding, memory access and the conditional-skip opcodes are handled outside this block. The caller keeps the overflow register and updates it only when the write-enable is high.

Top module: `ovfword_alu`

## Requirements
- R1: Opcode 0x2 (add) returns the low 16 bits of a+b. The overflow word is 0x0001 when the unsigned sum carries out of bit 15 and 0x0000 otherwise.
- R2: Opcode 0x3 (subtract) returns the low 16 bits of a-b. The overflow word is 0xFFFF when a < b (unsigned) and 0x0000 otherwise.
- R3: Opcode 0x4 (multiply) returns bits 15:0 of the unsigned 32-bit product, with bits 31:16 of that product as the overflow word.
- R4: Opcode 0x5 (divide) returns the unsigned quotient a/b, with the low 16 bits of (a·65536)/b as the overflow word. When b = 0, both the result and the overflow word are 0x0000.
- R5: Opcode 0x6 (modulo) returns a mod b, or 0x0000 when b = 0. The write-enable is low and the overflow word is 0x0000.
- R6: Opcode 0x7 (shift left) treats a shifted left by b as a 32-bit value. Bits 15:0 are the result and bits 31:16 are the overflow word.
- R7: Opcode 0x8 (shift right) treats a·65536 shifted right by b as a 32-bit value. Bits 31:16 are the result and bits 15:0 are the overflow word.
- R8: For opcodes 0x7 and 0x8, a shift amount b of 32 or more gives 0x0000 for both the result and the overflow word. The write-enable stays high.
- R9: Opcodes 0x1, 0x9, 0xA and 0xB return b, a AND b, a OR b and a XOR b. For these opcodes the write-enable is low and the overflow word is 0x0000.
- R10: The overflow write-enable is high exactly for opcodes 0x2, 0x3, 0x4, 0x5, 0x7 and 0x8.
- R11: Opcodes 0x0 and 0xC to 0xF return a unchanged. For these opcodes the write-enable is low and the overflow word is 0x0000.
- R12: With REG_OUT = 1, all outputs reflect the inputs sampled at the previous rising clock edge. While reset is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand, also the destination value |
| b_i | input | 16 | Second operand, also the shift amount |
| res_o | output | 16 | Value to write back to the destination |
| ovf_o | output | 16 | New overflow-register value |
| ovf_we_o | output | 1 | Write-enable for the overflow register |

## Verification
In the default configuration, every output is due exactly one rising edge after its operands are applied, because the only register on the path is the output stage. The bench drives each stimulus on a falling edge, waits for the next rising edge, and samples one time unit later. Each sample is compared with a model computed from that stimulus alone. The bound checker uses the same one-cycle offset: it compares the outputs with `$past` of the inputs, and it is armed only after the first edge out of reset.

// File: rtl/ovfword_pkg.sv
package ovfword_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 4'h0,
        OP_COPY = 4'h1,
        OP_ADD  = 4'h2,
        OP_SUB  = 4'h3,
        OP_MUL  = 4'h4,
        OP_DIV  = 4'h5,
        OP_MOD  = 4'h6,
        OP_SHL  = 4'h7,
        OP_SHR  = 4'h8,
        OP_AND  = 4'h9,
        OP_OR   = 4'hA,
        OP_XOR  = 4'hB
    } op_e;
endpackage

// File: rtl/ovfword_addmul.sv
// Add, subtract and multiply, each with its overflow word.
module ovfword_addmul #(
    parameter int W = ovfword_pkg::WORD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] sum_ovf_o,
    output logic [W-1:0] diff_o,
    output logic [W-1:0] diff_ovf_o,
    output logic [W-1:0] prod_lo_o,
    output logic [W-1:0] prod_hi_o
);
    localparam int PW = 2 * W;

    logic [W:0]    sum_w;
    logic [PW-1:0] prod_w;

    always_comb begin
        sum_w      = {1'b0, a_i} + {1'b0, b_i};
        sum_o      = sum_w[W-1:0];
        sum_ovf_o  = {{(W-1){1'b0}}, sum_w[W]};
        diff_o     = a_i - b_i;
        diff_ovf_o = (a_i < b_i) ? {W{1'b1}} : {W{1'b0}};
        prod_w     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        prod_lo_o  = prod_w[W-1:0];
        prod_hi_o  = prod_w[PW-1:W];
    end
endmodule

// File: rtl/ovfword_divmod.sv
// Unsigned quotient, fractional quotient and remainder, zero when b is zero.
module ovfword_divmod #(
    parameter int W = ovfword_pkg::WORD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] frac_o,
    output logic [W-1:0] rem_o
);
    localparam int PW = 2 * W;

    logic          b_zero;
    logic [PW-1:0] frac_num;
    logic [PW-1:0] frac_full;

    always_comb begin
        b_zero    = (b_i == '0);
        frac_num  = {a_i, {W{1'b0}}};
        frac_full = '0;
        quot_o    = '0;
        rem_o     = '0;
        if (!b_zero) begin
            quot_o    = a_i / b_i;
            rem_o     = a_i % b_i;
            frac_full = frac_num / {{W{1'b0}}, b_i};
        end
        frac_o = frac_full[W-1:0];
    end
endmodule

// File: rtl/ovfword_shift.sv
// Double-width shifts; amounts at or beyond 2*W clear both halves.
module ovfword_shift #(
    parameter int W = ovfword_pkg::WORD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] shl_res_o,
    output logic [W-1:0] shl_ovf_o,
    output logic [W-1:0] shr_res_o,
    output logic [W-1:0] shr_ovf_o
);
    localparam int PW  = 2 * W;
    localparam int SHW = $clog2(PW);

    logic           too_far;
    logic [SHW-1:0] amt;
    logic [PW-1:0]  left_w;
    logic [PW-1:0]  right_w;

    always_comb begin
        too_far = |b_i[W-1:SHW];
        amt     = b_i[SHW-1:0];
        left_w  = {{W{1'b0}}, a_i} << amt;
        right_w = {a_i, {W{1'b0}}} >> amt;
        if (too_far) begin
            left_w  = '0;
            right_w = '0;
        end
        shl_res_o = left_w[W-1:0];
        shl_ovf_o = left_w[PW-1:W];
        shr_res_o = right_w[PW-1:W];
        shr_ovf_o = right_w[W-1:0];
    end
endmodule

// File: rtl/ovfword_alu.sv
// Execute unit: selects one operation result and its overflow word.
module ovfword_alu #(
    parameter int W       = ovfword_pkg::WORD_W,
    parameter int OPW     = ovfword_pkg::OP_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   res_o,
    output logic [W-1:0]   ovf_o,
    output logic           ovf_we_o
);
    import ovfword_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
        logic [W-1:0] ovf;
        logic         we;
    } exec_t;

    logic [W-1:0] sum_w, sum_ovf_w, diff_w, diff_ovf_w, prod_lo_w, prod_hi_w;
    logic [W-1:0] quot_w, frac_w, rem_w;
    logic [W-1:0] shl_res_w, shl_ovf_w, shr_res_w, shr_ovf_w;

    ovfword_addmul #(.W(W)) addmul_i (
        .a_i        (a_i),
        .b_i        (b_i),
        .sum_o      (sum_w),
        .sum_ovf_o  (sum_ovf_w),
        .diff_o     (diff_w),
        .diff_ovf_o (diff_ovf_w),
        .prod_lo_o  (prod_lo_w),
        .prod_hi_o  (prod_hi_w)
    );

    ovfword_divmod #(.W(W)) divmod_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .quot_o (quot_w),
        .frac_o (frac_w),
        .rem_o  (rem_w)
    );

    ovfword_shift #(.W(W)) shift_i (
        .a_i       (a_i),
        .b_i       (b_i),
        .shl_res_o (shl_res_w),
        .shl_ovf_o (shl_ovf_w),
        .shr_res_o (shr_res_w),
        .shr_ovf_o (shr_ovf_w)
    );

    exec_t exe_d;

    always_comb begin
        exe_d = '{res: a_i, ovf: '0, we: 1'b0};
        case (op_e'(op_i))
            OP_COPY: exe_d.res = b_i;
            OP_ADD:  exe_d = '{res: sum_w,     ovf: sum_ovf_w,  we: 1'b1};
            OP_SUB:  exe_d = '{res: diff_w,    ovf: diff_ovf_w, we: 1'b1};
            OP_MUL:  exe_d = '{res: prod_lo_w, ovf: prod_hi_w,  we: 1'b1};
            OP_DIV:  exe_d = '{res: quot_w,    ovf: frac_w,     we: 1'b1};
            OP_MOD:  exe_d.res = rem_w;
            OP_SHL:  exe_d = '{res: shl_res_w, ovf: shl_ovf_w,  we: 1'b1};
            OP_SHR:  exe_d = '{res: shr_res_w, ovf: shr_ovf_w,  we: 1'b1};
            OP_AND:  exe_d.res = a_i & b_i;
            OP_OR:   exe_d.res = a_i | b_i;
            OP_XOR:  exe_d.res = a_i ^ b_i;
            default: exe_d.res = a_i;
        endcase
    end

    if (REG_OUT) begin : g_reg
        exec_t exe_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) exe_q <= '0;
            else         exe_q <= exe_d;
        end
        assign res_o    = exe_q.res;
        assign ovf_o    = exe_q.ovf;
        assign ovf_we_o = exe_q.we;
    end else begin : g_comb
        assign res_o    = exe_d.res;
        assign ovf_o    = exe_d.ovf;
        assign ovf_we_o = exe_d.we;
    end
endmodule

// File: rtl/ovfword_alu_chk.sv
module ovfword_alu_chk #(
    parameter int W       = 16,
    parameter int OPW     = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [OPW-1:0] op_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i,
    input logic [W-1:0]   res_o,
    input logic [W-1:0]   ovf_o,
    input logic           ovf_we_o
);
    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    if (REG_OUT) begin : g_props
        assert_we_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && ($past(op_i) inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h7, 4'h8}) |-> ovf_we_o);
        assert_we_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && !($past(op_i) inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h7, 4'h8}) |-> !ovf_we_o && ovf_o == '0);
        assert_add_carry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && $past(op_i) == 4'h2 |-> ovf_o <= 1);
        assert_sub_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && $past(op_i) == 4'h3 |-> (ovf_o == '0 || ovf_o == '1));
        assert_div_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && $past(op_i) == 4'h5 && $past(b_i) == '0 |-> res_o == '0 && ovf_o == '0);
        assert_mod_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && $past(op_i) == 4'h6 && $past(b_i) == '0 |-> res_o == '0);
        assert_shift_far_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && ($past(op_i) inside {4'h7, 4'h8}) && $past(b_i) >= 2 * W |-> res_o == '0 && ovf_o == '0);
        assert_copy_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && $past(op_i) == 4'h1 |-> res_o == $past(b_i));
        assert_pass_a_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            armed_q && ($past(op_i) inside {4'h0, 4'hC, 4'hD, 4'hE, 4'hF}) |-> res_o == $past(a_i));
    end
endmodule

bind ovfword_alu ovfword_alu_chk #(.W(W), .OPW(OPW), .REG_OUT(REG_OUT)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .res_o    (res_o),
    .ovf_o    (ovf_o),
    .ovf_we_o (ovf_we_o)
);

// File: tb/ovfword_alu_tb_top.sv
module ovfword_alu_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  op_i = '0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic [15:0] res_o, ovf_o;
    logic        ovf_we_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk_i = ~clk_i;

    ovfword_alu dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .res_o(res_o), .ovf_o(ovf_o), .ovf_we_o(ovf_we_o)
    );

    // Expected {res, ovf, we}, built from the requirement text.
    function automatic logic [32:0] model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] w;
        logic [15:0] r = a, o = 16'h0;
        logic        e = 1'b0;
        case (op)
            4'h1: r = b;
            4'h2: begin w = 32'(a) + 32'(b); r = w[15:0]; o = (w > 32'hFFFF) ? 16'h1 : 16'h0; e = 1; end
            4'h3: begin r = a - b; o = (a < b) ? 16'hFFFF : 16'h0; e = 1; end
            4'h4: begin w = 32'(a) * 32'(b); r = w[15:0]; o = w[31:16]; e = 1; end
            4'h5: begin
                e = 1;
                if (b != 0) begin r = a / b; w = (32'(a) << 16) / 32'(b); o = w[15:0]; end
                else begin r = 0; o = 0; end
            end
            4'h6: r = (b != 0) ? a % b : 16'h0;
            4'h7: begin e = 1; w = (b >= 32) ? 32'h0 : (32'(a) << b); r = w[15:0]; o = w[31:16]; end
            4'h8: begin e = 1; w = (b >= 32) ? 32'h0 : ((32'(a) << 16) >> b); r = w[31:16]; o = w[15:0]; end
            4'h9: r = a & b;
            4'hA: r = a | b;
            4'hB: r = a ^ b;
            default: r = a;
        endcase
        return {r, o, e};
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic [15:0] b);
        case (op)
            4'h2: return "R1";
            4'h3: return "R2";
            4'h4: return "R3";
            4'h5: return "R4";
            4'h6: return "R5";
            4'h7: return (b >= 32) ? "R8" : "R6";
            4'h8: return (b >= 32) ? "R8" : "R7";
            4'h1, 4'h9, 4'hA, 4'hB: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic run(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        logic [32:0] exp_v;
        @(negedge clk_i);
        op_i = op; a_i = a; b_i = b;
        exp_v = model(op, a, b);
        @(posedge clk_i);
        #1;
        n_tests++;
        if ({res_o, ovf_o} != exp_v[32:1]) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h: got res=%h ovf=%h, expected res=%h ovf=%h",
                     req_of(op, b), op, a, b, res_o, ovf_o, exp_v[32:17], exp_v[16:1]);
        end
        n_tests++;
        if (ovf_we_o != exp_v[0]) begin
            n_fail++;
            $display("FAIL R10 op=%h: got we=%b, expected we=%b", op, ovf_we_o, exp_v[0]);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0016));
        op_i = 4'h2; a_i = 16'hFFFF; b_i = 16'h0001;
        repeat (3) @(posedge clk_i);
        #1;
        n_tests++;  // R12: outputs held at zero during reset
        if (res_o !== 16'h0 || ovf_o !== 16'h0 || ovf_we_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 reset: got %h/%h/%b, expected 0000/0000/0", res_o, ovf_o, ovf_we_o);
        end
        @(negedge clk_i);
        rst_ni = 1'b1;

        run(4'h2, 16'hFFFF, 16'h0001);  // R1 carry
        run(4'h2, 16'h1234, 16'h0001);  // R1 no carry
        run(4'h3, 16'h0000, 16'h0001);  // R2 borrow
        run(4'h3, 16'h0005, 16'h0005);  // R2 equal
        run(4'h4, 16'hFFFF, 16'hFFFF);  // R3
        run(4'h5, 16'h0001, 16'h0003);  // R4 fraction 0x5555
        run(4'h5, 16'h1234, 16'h0000);  // R4 divide by zero
        run(4'h6, 16'h0007, 16'h0000);  // R5 modulo by zero
        run(4'h6, 16'h0064, 16'h0007);  // R5
        run(4'h7, 16'h8001, 16'h0001);  // R6
        run(4'h7, 16'h00F3, 16'h0010);  // R6 shift 16
        run(4'h7, 16'hFFFF, 16'h001F);  // R6 shift 31
        run(4'h7, 16'hFFFF, 16'h0020);  // R8 shift 32
        run(4'h8, 16'h8001, 16'h0001);  // R7
        run(4'h8, 16'hABCD, 16'h001F);  // R7 shift 31
        run(4'h8, 16'hFFFF, 16'hFFFF);  // R8
        run(4'h1, 16'h1111, 16'h2222);  // R9
        run(4'hB, 16'hF0F0, 16'hFF00);  // R9
        run(4'h0, 16'hBEEF, 16'h0001);  // R11
        run(4'hF, 16'hCAFE, 16'h0002);  // R11

        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  op = 4'($urandom_range(0, 15));
            logic [15:0] a  = 16'($urandom);
            logic [15:0] b  = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 40)) : 16'($urandom);
            run(op, a, b);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule